// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block holds two programmable alarms and compares them with the running BCD clock and calendar once per second. Each alarm byte carries a "don't care" bit in its top position, so an alarm can fire every second, every minute, or on a chosen time, weekday or day of month. The second alarm has no seconds byte. It can only fire when the seconds count is 00. When an alarm matches on a tick, the alarm's sticky flag is set. The flag stays set until software writes a zero to it.

A single active-low output pin serves two uses. In interrupt mode it goes low whenever an enabled flag is set. In square-wave mode it follows one of four prescaler taps, chosen by a two-bit rate field. When main power is reported absent, the pin is released (driven high) unless a backup-operation bit in the control byte allows it to keep running. The clock counters, the serial bus and the power switch-over are outside this block. They reach it through the current-time inputs, the tick, a simple write port and `vcc_ok`.

Top module: `alarm_pair_irq`

## Requirements
- R1: After synchronous reset both flags are 0, and the control byte resets to these values: both enables 0, mode bit 0, backup bit 0, rate 3. The pin therefore follows `sq_taps[3]`.
- R2: Alarm 1 compares seconds, minutes, hours and day/date. A byte whose bit 7 is 1 is excluded from the compare. An included byte matches when its bits 6:0 equal the current BCD byte. Hours are compared exactly as stored, so the 12/24 and AM/PM bits must also match.
- R3: In a day/date alarm byte, bit 6 selects the compare target: 1 compares bits 5:0 with the day of week, and 0 compares them with the date of month.
- R4: Alarm 2 has only minutes, hours and day/date bytes, with the same masking rules. It can match only while the current seconds are 00. With all its masks set, it fires once per minute.
- R5: Matches are evaluated only in a cycle where `tick_1hz` is high. The flag is visible one clock later. Matching time values with no tick never set a flag.
- R6: Writing the status address clears a flag where the data bit is 0: bit 0 for alarm 1, bit 1 for alarm 2. A data bit of 1 leaves its flag unchanged. Flags are otherwise sticky.
- R7: If a tick match and a clearing status write fall in the same cycle, the flag ends up set.
- R8: The control byte holds these fields: bit 0 enables alarm 1, bit 1 enables alarm 2, bit 2 selects interrupt mode, bits 4:3 hold the rate, and bit 5 is the backup bit. In interrupt mode the pin is low exactly when (flag1 and enable1) or (flag2 and enable2) is true.
- R9: With bit 2 at 0, the pin equals `sq_taps[rate]`. Rate 0 selects the 1 Hz tap, rate 1 the 4.096 kHz tap, rate 2 the 8.192 kHz tap and rate 3 the 32.768 kHz tap.
- R10: With `vcc_ok` low and the backup bit 0, the pin is high. With the backup bit 1, the pin behaves as in R8/R9.
- R11: The write addresses are assigned as follows: 0 to 3 hold alarm 1 seconds, minutes, hours and day/date; 4 to 6 hold alarm 2 minutes, hours and day/date; 7 is control; 8 is status. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours byte as stored (mode and AM/PM bits included) |
| now_dow | input | 8 | Current day of week |
| now_date | input | 8 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| sq_taps | input | 4 | Prescaler square-wave taps, index = rate code |
| vcc_ok | input | 1 | Main power present |
| flag_a1 | output | 1 | Alarm 1 sticky flag |
| flag_a2 | output | 1 | Alarm 2 sticky flag |
| irq_n | output | 1 | Shared interrupt / square-wave pin level, high when released |

## Verification
The assertions watch the relation between a flag, the tick and status writes on every cycle. A flag may rise only after a tick, fall only after a zero written to its bit, and hold across a write of one. They also check the pin against the control byte, the flags and the taps in every mode, including release on power loss. The full mask-and-field behaviour of each alarm, the day-versus-date selection and the hours compare with mode bits can only be shown by the bench. The bench sweeps every mask pattern against every combination of matching and non-matching time fields.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int N_ALARMS = 2;
    localparam int N_TAPS   = 4;
    localparam int RATE_W   = $clog2(N_TAPS);
    localparam int ALM_STRIDE = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd8;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dd;
    } alm_regs_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] date;
    } tod_t;

    typedef struct packed {
        logic              batt_en;
        logic [RATE_W-1:0] rate;
        logic              int_mode;
        logic              ie2;
        logic              ie1;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RESET = '{batt_en: 1'b0, rate: '1, int_mode: 1'b0,
                                     ie2: 1'b0, ie1: 1'b0};

    // Bit 7 masks the byte out; otherwise the low seven bits must equal the time byte.
    function automatic logic fld_hit(input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] cur);
        return a[7] | ({1'b0, a[6:0]} == cur);
    endfunction

    // Bit 6 picks weekday (1) or date of month (0) as the target.
    function automatic logic dd_hit(input logic [BYTE_W-1:0] a,
                                    input logic [BYTE_W-1:0] dow,
                                    input logic [BYTE_W-1:0] date);
        logic [BYTE_W-1:0] tgt;
        tgt = a[6] ? dow : date;
        return a[7] | ({2'b00, a[5:0]} == tgt);
    endfunction

endpackage

// File: rtl/alm_match.sv
`timescale 1ns/1ps
module alm_match
    import alm_pkg::*;
(
    input  alm_regs_t cfg,
    input  tod_t      now,
    output logic      hit
);
    always_comb begin
        hit = fld_hit(cfg.sec,  now.sec)
            & fld_hit(cfg.min,  now.min)
            & fld_hit(cfg.hour, now.hour)
            & dd_hit(cfg.dd, now.dow, now.date);
    end
endmodule

// File: rtl/alm_flags.sv
`timescale 1ns/1ps
module alm_flags
    import alm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [N_ALARMS-1:0] hit,
    input  logic                clr_we,
    input  logic [N_ALARMS-1:0] keep,
    output logic [N_ALARMS-1:0] flag_q
);
    logic [N_ALARMS-1:0] kept, setv;

    always_comb begin
        kept = clr_we ? (flag_q & keep) : flag_q;
        setv = tick ? hit : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= kept | setv;   // a new match outranks a clear
    end
endmodule

// File: rtl/alm_pin_mux.sv
`timescale 1ns/1ps
module alm_pin_mux
    import alm_pkg::*;
(
    input  ctrl_t               ctrl,
    input  logic [N_ALARMS-1:0] flags,
    input  logic [N_TAPS-1:0]   taps,
    input  logic                vcc_ok,
    output logic                pin_n
);
    logic active, drive;

    always_comb begin
        active = |(flags & {ctrl.ie2, ctrl.ie1});
        drive  = ctrl.int_mode ? ~active : taps[ctrl.rate];
        pin_n  = (vcc_ok || ctrl.batt_en) ? drive : 1'b1;
    end
endmodule

// File: rtl/alarm_pair_irq.sv
`timescale 1ns/1ps
module alarm_pair_irq
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [BYTE_W-1:0] now_sec,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_dow,
    input  logic [BYTE_W-1:0] now_date,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [N_TAPS-1:0] sq_taps,
    input  logic              vcc_ok,
    output logic              flag_a1,
    output logic              flag_a2,
    output logic              irq_n
);
    tod_t                now;
    alm_regs_t           cfg [N_ALARMS];
    logic [N_ALARMS-1:0] hit;
    logic [N_ALARMS-1:0] flag_q;
    ctrl_t               ctrl_q;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour,
                   dow: now_dow, date: now_date};

    for (genvar g = 0; g < N_ALARMS; g++) begin : g_alm
        localparam bit HAS_SEC = (g == 0);
        localparam int OFS     = HAS_SEC ? 1 : 0;
        localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(g * ALM_STRIDE);
        localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(g * ALM_STRIDE + OFS);
        localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(g * ALM_STRIDE + OFS + 1);
        localparam logic [ADDR_W-1:0] A_DD   = ADDR_W'(g * ALM_STRIDE + OFS + 2);

        logic [BYTE_W-1:0] sec_q, min_q, hour_q, dd_q;

        if (HAS_SEC) begin : g_sec
            always_ff @(posedge clk) begin
                if (rst)                          sec_q <= '0;
                else if (wr_en && wr_addr == A_SEC) sec_q <= wr_data;
            end
        end else begin : g_nosec
            // Fixed, unmasked seconds byte of 00: matches only at the minute.
            assign sec_q = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                min_q  <= '0;
                hour_q <= '0;
                dd_q   <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_MIN)  min_q  <= wr_data;
                if (wr_addr == A_HOUR) hour_q <= wr_data;
                if (wr_addr == A_DD)   dd_q   <= wr_data;
            end
        end

        assign cfg[g] = '{sec: sec_q, min: min_q, hour: hour_q, dd: dd_q};

        alm_match u_match (
            .cfg (cfg[g]),
            .now (now),
            .hit (hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                                ctrl_q <= CTRL_RESET;
        else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    alm_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .hit    (hit),
        .clr_we (wr_en && wr_addr == ADDR_STATUS),
        .keep   (wr_data[N_ALARMS-1:0]),
        .flag_q (flag_q)
    );

    alm_pin_mux u_pin (
        .ctrl   (ctrl_q),
        .flags  (flag_q),
        .taps   (sq_taps),
        .vcc_ok (vcc_ok),
        .pin_n  (irq_n)
    );

    assign flag_a1 = flag_q[0];
    assign flag_a2 = flag_q[1];
endmodule

// File: rtl/alarm_pair_irq_chk.sv
`timescale 1ns/1ps
module alarm_pair_irq_chk
    import alm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [N_TAPS-1:0] sq_taps,
    input logic              vcc_ok,
    input logic              flag_a1,
    input logic              flag_a2,
    input logic              irq_n,
    input ctrl_t             ctrl_q
);
    logic st_wr;
    assign st_wr = wr_en && (wr_addr == ADDR_STATUS);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!flag_a1 && !flag_a2));

    p_rise_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_a1) || $rose(flag_a2)) |-> $past(tick_1hz));

    p_fall_a1_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_a1) |-> $past(st_wr && !wr_data[0]));

    p_fall_a2_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_a2) |-> $past(st_wr && !wr_data[1]));

    p_one_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (st_wr && wr_data[0] && wr_data[1] && !tick_1hz) |=> ($stable(flag_a1) && $stable(flag_a2)));

    p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.int_mode && vcc_ok) |->
            (irq_n == !((flag_a1 && ctrl_q.ie1) || (flag_a2 && ctrl_q.ie2))));

    p_square_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.int_mode && vcc_ok) |-> (irq_n == sq_taps[ctrl_q.rate]));

    p_backup_release_r10: assert property (@(posedge clk) disable iff (rst)
        (!vcc_ok && !ctrl_q.batt_en) |-> irq_n);
endmodule

bind alarm_pair_irq alarm_pair_irq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sq_taps  (sq_taps),
    .vcc_ok   (vcc_ok),
    .flag_a1  (flag_a1),
    .flag_a2  (flag_a2),
    .irq_n    (irq_n),
    .ctrl_q   (ctrl_q)
);

// File: tb/alarm_pair_irq_tb.sv
`timescale 1ns/1ps
module alarm_pair_irq_tb;
    import alm_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, tick_1hz, wr_en, vcc_ok;
    logic [7:0] now_sec, now_min, now_hour, now_dow, now_date, wr_data;
    logic [3:0] wr_addr, sq_taps;
    logic       flag_a1, flag_a2, irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    alarm_pair_irq u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_dow(now_dow), .now_date(now_date),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sq_taps(sq_taps), .vcc_ok(vcc_ok),
        .flag_a1(flag_a1), .flag_a2(flag_a2), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick_at(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] dw, input logic [7:0] dt);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_dow = dw; now_date = dt;
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick_1hz = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        now_sec = 8'h01; now_min = 8'h01; now_hour = 8'h01; now_dow = 8'h01; now_date = 8'h01;
        sq_taps = '0; vcc_ok = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 flag_a1", flag_a1, 1'b0);
        chk("R1 flag_a2", flag_a2, 1'b0);
        for (int p = 0; p < 16; p++) begin
            sq_taps = 4'(p); #1;
            chk("R1 pin follows tap 3", irq_n, sq_taps[3]);
        end

        // R9: every rate against every tap pattern
        for (int r = 0; r < 4; r++) begin
            wr(ADDR_CTRL, 8'(r << 3));
            for (int p = 0; p < 16; p++) begin
                sq_taps = 4'(p); #1;
                chk("R9 square tap", irq_n, sq_taps[r]);
            end
        end

        // R10: power loss in square mode
        vcc_ok = 1'b0;
        wr(ADDR_CTRL, 8'h18);
        for (int p = 0; p < 16; p++) begin
            sq_taps = 4'(p); #1;
            chk("R10 released", irq_n, 1'b1);
        end
        wr(ADDR_CTRL, 8'h38);
        for (int p = 0; p < 16; p++) begin
            sq_taps = 4'(p); #1;
            chk("R10 backup runs", irq_n, sq_taps[3]);
        end
        vcc_ok = 1'b1;

        // R2 / R3: alarm 1 all masks x all field hit patterns x day/date select
        for (int m = 0; m < 16; m++) begin
            for (int dy = 0; dy < 2; dy++) begin
                wr(4'd0, {m[0], 7'h30});
                wr(4'd1, {m[1], 7'h15});
                wr(4'd2, {m[2], 7'h47});
                wr(4'd3, {m[3], dy[0], (dy != 0) ? 6'h05 : 6'h14});
                wr(ADDR_STATUS, 8'h00);
                for (int f = 0; f < 32; f++) begin
                    logic e;
                    tick_at(f[0] ? 8'h30 : 8'h31,
                            f[1] ? 8'h15 : 8'h16,
                            f[2] ? 8'h47 : 8'h07,
                            f[4] ? 8'h05 : 8'h06,
                            f[3] ? 8'h14 : 8'h15);
                    e = (m[0] | f[0]) & (m[1] | f[1]) & (m[2] | f[2])
                      & (m[3] | ((dy != 0) ? f[4] : f[3]));
                    if (dy != 0) chk("R3 alarm1 weekday", flag_a1, e);
                    else         chk("R2 alarm1 date", flag_a1, e);
                    wr(ADDR_STATUS, 8'h00);
                end
            end
        end

        // R4: alarm 2 sweep, seconds must be 00
        for (int m = 0; m < 8; m++) begin
            for (int dy = 0; dy < 2; dy++) begin
                wr(4'd4, {m[0], 7'h15});
                wr(4'd5, {m[1], 7'h47});
                wr(4'd6, {m[2], dy[0], (dy != 0) ? 6'h05 : 6'h14});
                wr(ADDR_STATUS, 8'h00);
                for (int f = 0; f < 32; f++) begin
                    logic e;
                    tick_at(f[0] ? 8'h00 : 8'h30,
                            f[1] ? 8'h15 : 8'h16,
                            f[2] ? 8'h47 : 8'h07,
                            f[4] ? 8'h05 : 8'h06,
                            f[3] ? 8'h14 : 8'h15);
                    e = f[0] & (m[0] | f[1]) & (m[1] | f[2])
                      & (m[2] | ((dy != 0) ? f[4] : f[3]));
                    chk("R4 alarm2", flag_a2, e);
                    wr(ADDR_STATUS, 8'h00);
                end
            end
        end

        // R5: no tick, no flag; flag appears one clock after the tick
        wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
        wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
        wr(ADDR_STATUS, 8'h00);
        now_sec = 8'h00;
        repeat (5) @(negedge clk);
        chk("R5 no tick a1", flag_a1, 1'b0);
        chk("R5 no tick a2", flag_a2, 1'b0);
        tick_1hz = 1'b1; #1;
        chk("R5 not before edge", flag_a1, 1'b0);
        @(negedge clk);
        tick_1hz = 1'b0;
        chk("R5 set after tick a1", flag_a1, 1'b1);
        chk("R4 once per minute", flag_a2, 1'b1);

        // R6: write-one keeps, write-zero clears per bit
        wr(ADDR_STATUS, 8'hFF);
        chk("R6 keep a1", flag_a1, 1'b1);
        chk("R6 keep a2", flag_a2, 1'b1);
        wr(ADDR_STATUS, 8'h02);
        chk("R6 clear a1", flag_a1, 1'b0);
        chk("R6 spare a2", flag_a2, 1'b1);
        wr(ADDR_STATUS, 8'h01);
        chk("R6 clear a2", flag_a2, 1'b0);
        chk("R6 a1 stays clear", flag_a1, 1'b0);

        // R11: unmapped addresses change nothing
        tick_at(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        wr(4'd9, 8'h00);
        wr(4'd15, 8'h00);
        chk("R11 a1 untouched", flag_a1, 1'b1);
        chk("R11 a2 untouched", flag_a2, 1'b1);

        // R7: set wins over a clear in the same cycle
        wr(ADDR_STATUS, 8'h00);
        @(negedge clk);
        now_sec = 8'h30; tick_1hz = 1'b1;
        wr_en = 1'b1; wr_addr = ADDR_STATUS; wr_data = 8'h00;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        chk("R7 set wins a1", flag_a1, 1'b1);
        chk("R7 no hit a2", flag_a2, 1'b0);

        // R8: interrupt mode over all flag and enable combinations
        for (int fs = 0; fs < 4; fs++) begin
            for (int ie = 0; ie < 4; ie++) begin
                wr(ADDR_STATUS, 8'h00);
                if (fs != 0) begin
                    tick_at(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
                    wr(ADDR_STATUS, {6'b0, fs[1], fs[0]});
                end
                wr(ADDR_CTRL, {5'b0, 1'b1, ie[1], ie[0]});
                #1;
                chk("R8 irq level", irq_n, !((fs[0] & ie[0]) | (fs[1] & ie[1])));
            end
        end

        // R10 in interrupt mode
        tick_at(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        wr(ADDR_CTRL, 8'h07);
        vcc_ok = 1'b0; #1;
        chk("R10 irq released", irq_n, 1'b1);
        wr(ADDR_CTRL, 8'h27); #1;
        chk("R10 irq in backup", irq_n, 1'b0);
        vcc_ok = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule